// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Controller

This block takes a stream of received bytes and places them into memory buffers. Each buffer is described by an 8-byte descriptor that sits in a small descriptor RAM inside the block. Software fills the descriptors through a host port and marks each one ready. The controller opens the descriptor at its current ring position, copies the buffer pointer into a running data pointer and loads a remaining-space counter from the configured maximum buffer length. It then emits one memory byte write for every accepted input byte.

A buffer closes in three cases: its space runs out, the input marks end of frame, or the input marks an error. On close, the controller writes the byte count and status back into the descriptor and hands the descriptor back to software by clearing its ready bit. It pulses an interrupt and moves to the next descriptor 8 bytes on. When the closed descriptor carries the wrap bit, the next descriptor is the ring base instead. The ring length therefore comes from where software places the wrap bit, not from a fixed count. A new maximum length is sampled only when a descriptor is opened.

Descriptor layout, as a 64-bit word: bits 63..32 hold the buffer pointer and bits 31..16 hold the received length. Bit 15 is the ready (empty) bit, bit 13 is wrap, bit 1 is end of frame and bit 0 is error. The host port addresses the descriptor RAM by byte address, and bits 2..0 of that address are ignored.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset there is no memory write and no interrupt, `ring_full` and `cfg_err` are low, the ring base is 0, and the first descriptor used is the one at the ring base.
- R2: While a buffer is open, each input byte with `in_valid` high produces a memory write in the same cycle. The address is the buffer pointer plus the number of bytes already written to that buffer.
- R3: After as many bytes as the maximum length latched at open, the buffer closes. The written-back length equals that maximum, and the end-of-frame and error bits (1 and 0) are clear.
- R4: A byte with `in_eof` high is written and closes the buffer early. The written-back length is the number of bytes written, and bit 1 is set.
- R5: A byte with `in_err` high is written and closes the buffer early. The written-back length is the number of bytes written, and bit 0 is set.
- R6: On close, the ready bit 15 is cleared while the wrap bit 13 and the buffer pointer are kept. `buf_irq` is high for exactly the one cycle after the closing byte.
- R7: After a close, the next descriptor is at the current descriptor address plus 8. If the closed descriptor has wrap bit 13 set, the next descriptor is the ring base.
- R8: A maximum length written while a buffer is open does not change when that buffer closes. It applies from the next descriptor opened.
- R9: When the descriptor at the ring position has ready bit 15 clear, `ring_full` is high and input bytes are discarded with no memory write. Once software sets bit 15, reception resumes in that descriptor. A byte that arrives in the single cycle between a close and the next open is also discarded.
- R10: A ring base with bits 2..0 not zero, or a maximum length of 0, raises `cfg_err`. While `cfg_err` is high the receiver stays disabled, performs no memory writes, and returns its descriptor position to the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| cfg_base_we | input | 1 | Load ring base register |
| cfg_base | input | ADDR_W | Ring base byte address in descriptor RAM |
| cfg_len_we | input | 1 | Load maximum buffer length register (single 16-bit write) |
| cfg_len | input | 16 | Maximum buffer length |
| host_we | input | 1 | Host write of one descriptor |
| host_addr | input | ADDR_W | Host descriptor byte address |
| host_wdata | input | 64 | Descriptor write data |
| host_rdata | output | 64 | Descriptor read data at host_addr |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Byte is last of frame |
| in_err | input | 1 | Byte carries a receive error |
| mem_we | output | 1 | Buffer memory byte write strobe |
| mem_addr | output | 32 | Buffer memory byte address |
| mem_data | output | 8 | Buffer memory byte data |
| buf_irq | output | 1 | One-cycle pulse per closed buffer |
| ring_full | output | 1 | Ring position holds no ready descriptor |
| cfg_err | output | 1 | Configuration rejected |

## Verification
Every cycle, the assertions check that an open buffer never has zero space left. They check that the data pointer steps by one after each non-closing write, that every close is followed by the interrupt, and that a wrap close returns to the ring base. They also check that no memory write happens while the configuration is rejected or the ring is full. The bench scenarios are needed for the rest: the written-back lengths and status bits, the order of descriptor use around the ring, the deferred effect of a length change, and resumption after software re-arms a descriptor. None of these can be judged from a single cycle.

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl #(
  parameter int ADDR_W  = 7,
  parameter int RST_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              cfg_base_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_len_we,
  input  logic [15:0]       cfg_len,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_eof,
  input  logic              in_err,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [7:0]        mem_data,
  output logic              buf_irq,
  output logic              ring_full,
  output logic              cfg_err
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int DEPTH = 1 << IDX_W;
  localparam int RDY_B = 15;
  localparam int WRP_B = 13;
  localparam int EOF_B = 1;
  localparam int ERR_B = 0;

  logic [63:0]       ring [DEPTH];
  logic [ADDR_W-1:0] base_q, ptr_q;
  logic [15:0]       len_q, remain_q, cnt_q;
  logic [31:0]       dptr_q;
  logic              recv_q, irq_q;
  logic [63:0]       cur, wb;
  logic              active, close;

  assign cur        = ring[ptr_q[ADDR_W-1:3]];
  assign host_rdata = ring[host_addr[ADDR_W-1:3]];
  assign cfg_err    = (base_q[2:0] != 3'd0) || (len_q == 16'd0);
  assign active     = rx_en && !cfg_err;
  assign mem_we     = active && recv_q && in_valid;
  assign mem_addr   = dptr_q;
  assign mem_data   = in_data;
  assign close      = mem_we && (remain_q == 16'd1 || in_eof || in_err);
  assign ring_full  = active && !recv_q && !cur[RDY_B];
  assign buf_irq    = irq_q;

  always_comb begin
    wb         = cur;
    wb[31:16]  = cnt_q + 16'd1;
    wb[RDY_B]  = 1'b0;
    wb[EOF_B]  = in_eof;
    wb[ERR_B]  = in_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= 16'(RST_LEN);
    end else begin
      if (cfg_base_we) base_q <= cfg_base;
      if (cfg_len_we)  len_q  <= cfg_len;
    end
  end

  always_ff @(posedge clk) begin
    if (close)        ring[ptr_q[ADDR_W-1:3]]     <= wb;
    else if (host_we) ring[host_addr[ADDR_W-1:3]] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      recv_q   <= 1'b0;
      dptr_q   <= '0;
      remain_q <= '0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= close;
      if (!active) begin
        ptr_q  <= base_q;
        recv_q <= 1'b0;
      end else if (!recv_q) begin
        if (cur[RDY_B]) begin
          recv_q   <= 1'b1;
          dptr_q   <= cur[63:32];
          remain_q <= len_q;
          cnt_q    <= '0;
        end
      end else if (mem_we) begin
        dptr_q   <= dptr_q + 32'd1;
        remain_q <= remain_q - 16'd1;
        cnt_q    <= cnt_q + 16'd1;
        if (close) begin
          recv_q <= 1'b0;
          ptr_q  <= cur[WRP_B] ? base_q : ptr_q + ADDR_W'(8);
        end
      end
    end
  end

  p_space_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    recv_q |-> remain_q != 16'd0);
  p_dptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !close) |=> dptr_q == $past(dptr_q) + 32'd1);
  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> buf_irq);
  p_wrap_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (close && cur[WRP_B]) |=> ptr_q == $past(base_q));
  p_cfg_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !mem_we);
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> !mem_we);
endmodule

// File: tb/rx_ring_ctrl_tb_top.sv
module rx_ring_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic clk = 0, rst_n = 0, rx_en = 0;
  logic cfg_base_we = 0, cfg_len_we = 0, host_we = 0;
  logic [AW-1:0] cfg_base = '0, host_addr = '0;
  logic [15:0] cfg_len = '0;
  logic [63:0] host_wdata = '0, host_rdata;
  logic in_valid = 0, in_eof = 0, in_err = 0;
  logic [7:0] in_data = '0;
  logic mem_we, buf_irq, ring_full, cfg_err;
  logic [31:0] mem_addr;
  logic [7:0] mem_data;

  int checks = 0, failures = 0, irq_cnt = 0;
  bit started = 0;
  logic [39:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_ctrl #(.ADDR_W(AW), .RST_LEN(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof), .in_err(in_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .buf_irq(buf_irq), .ring_full(ring_full), .cfg_err(cfg_err));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    if (buf_irq) irq_cnt++;
    if (mem_we) begin
      logic [39:0] e;
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R2/R9/R10 unexpected write got=%h_%h exp=none", mem_addr, mem_data);
      end else begin
        e = expq.pop_front();
        if ({mem_addr, mem_data} !== e) begin
          failures++;
          $display("FAIL R2 write got=%h exp=%h", {mem_addr, mem_data}, e);
        end
      end
    end
  end

  function automatic logic [63:0] mk(input logic [31:0] p, input logic [15:0] l,
                                     input bit rdy, input bit wrp, input bit f, input bit x);
    logic [63:0] d = '0;
    d[63:32] = p; d[31:16] = l; d[15] = rdy; d[13] = wrp; d[1] = f; d[0] = x;
    return d;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(posedge clk); #1;
    host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic set_len(input logic [15:0] v);
    @(posedge clk); #1; cfg_len_we = 1; cfg_len = v;
    @(posedge clk); #1; cfg_len_we = 0;
  endtask

  task automatic set_base(input logic [AW-1:0] v);
    @(posedge clk); #1; cfg_base_we = 1; cfg_base = v;
    @(posedge clk); #1; cfg_base_we = 0;
  endtask

  task automatic send(input logic [7:0] d, input bit f, input bit x,
                      input bit exp, input logic [31:0] a);
    @(posedge clk); #1;
    if (exp) expq.push_back({a, d});
    in_valid = 1; in_data = d; in_eof = f; in_err = x;
    @(posedge clk); #1;
    in_valid = 0; in_eof = 0; in_err = 0;
  endtask

  initial begin
    logic [63:0] r;
    cyc(2);
    rst_n = 1;
    started = 1;
    cyc(1);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 irq", buf_irq, 0);
    chk("R1 ring_full", ring_full, 0);
    chk("R1 cfg_err", cfg_err, 0);

    set_len(16'd4);
    host_wr(7'd0,  mk(32'h1000, 0, 1, 0, 0, 0));
    host_wr(7'd8,  mk(32'h2000, 0, 1, 0, 0, 0));
    host_wr(7'd16, mk(32'h2800, 0, 1, 1, 0, 0));
    rx_en = 1;
    cyc(2);

    for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i), 0, 0, 1, 32'h1000 + i);
    cyc(1);
    rd(7'd0, r);
    chk("R3 full close desc0", r, mk(32'h1000, 4, 0, 0, 0, 0));
    chk("R6 irq one pulse", 64'(irq_cnt), 1);

    send(8'h11, 0, 0, 1, 32'h2000);
    send(8'h22, 1, 0, 1, 32'h2001);
    cyc(1);
    rd(7'd8, r);
    chk("R4 eof close desc1", r, mk(32'h2000, 2, 0, 0, 1, 0));

    send(8'h33, 0, 1, 1, 32'h2800);
    cyc(1);
    rd(7'd16, r);
    chk("R5 err close desc2 keeps wrap", r, mk(32'h2800, 1, 0, 1, 0, 1));
    chk("R6 irq count", 64'(irq_cnt), 3);

    cyc(1);
    chk("R9 ring_full after wrap to non-ready", ring_full, 1);
    send(8'h44, 0, 0, 0, 0);
    chk("R9 no write while full", 64'(expq.size()), 0);

    host_wr(7'd0, mk(32'h3000, 0, 1, 0, 0, 0));
    host_wr(7'd8, mk(32'h4000, 0, 1, 0, 0, 0));
    chk("R9 ring_full cleared", ring_full, 0);
    send(8'h50, 0, 0, 1, 32'h3000);
    send(8'h51, 0, 0, 1, 32'h3001);
    set_len(16'd2);
    send(8'h52, 0, 0, 1, 32'h3002);
    send(8'h53, 0, 0, 1, 32'h3003);
    cyc(1);
    rd(7'd0, r);
    chk("R7/R8 wrap reuse, old length kept", r, mk(32'h3000, 4, 0, 0, 0, 0));
    send(8'h60, 0, 0, 1, 32'h4000);
    send(8'h61, 0, 0, 1, 32'h4001);
    cyc(1);
    rd(7'd8, r);
    chk("R8 new length on next desc", r, mk(32'h4000, 2, 0, 0, 0, 0));
    chk("R7 next desc2 not ready", ring_full, 1);

    set_base(7'd3);
    chk("R10 misaligned base", cfg_err, 1);
    send(8'h70, 0, 0, 0, 0);
    set_base(7'd0);
    set_len(16'd0);
    chk("R10 zero length", cfg_err, 1);
    send(8'h71, 0, 0, 0, 0);
    set_len(16'd4);
    chk("R10 recovered", cfg_err, 0);
    cyc(2);
    chk("R2 queue drained", 64'(expq.size()), 0);
    chk("R6 irq total", 64'(irq_cnt), 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule